// File: doc/BRIEF.md
# Chipset Register Bus Decoder

This block sits between a processor bus and a small set of chipset control registers. Each access presents an address, a direction and, for writes, a 16-bit data word. The block decodes a word-aligned register offset from the address and either returns read data one cycle later or updates a register. It holds the DMA control word, the interrupt enable and request words, the audio/disk control word, a collision control word and a latch that gathers collision hits. It also folds the enabled interrupt requests into a single pending output.

The DMA, interrupt and audio/disk words use set/clear writes: the top data bit selects whether the other masked bits are set or cleared. Most state is written at one offset and read back at another. Accesses that land where the chosen direction has no register are not dropped. A read with no readable register returns all ones and also performs a write of all ones to that offset. A write with no writable register performs the read of that offset, side effects included. Writes that belong to engines outside this block (blitter, audio, disk, video) are passed out as a one-cycle strobe that carries the offset and the data. Beam position readback is taken from counters supplied from outside.

Top module: `chip_regbus`

## Requirements
- R1: The register offset is address bits 8..1 with bit 0 forced to zero. Address bit 0 and all bits above bit 8 have no effect on decoding.
- R2: The DMA control word (write offset 0x024, mask 0x1FFF) takes set/clear writes. When data bit 15 is 1, the masked data bits are ORed in. When it is 0, the masked data bits are cleared. The result shows on `dma_ctl_o` after the access edge.
- R3: Interrupt enable (write 0x026, read 0x00E), interrupt request (write 0x028, read 0x010) and audio/disk control (write 0x02A, read 0x008) take set/clear writes with mask 0x7FFF, so their bit 15 always reads 0.
- R4: A read of an offset with no readable register returns 0xFFFF. It also performs a write of 0xFFFF to that offset. For example, a read of 0x026 sets interrupt enable to 0x7FFF.
- R5: A write to an offset with no writable register performs the read of that offset with its side effects, and discards the result: `rd_data_o` keeps its previous value.
- R6: A read of the collision offset 0x006 returns the latched hits and clears the latch in the same access. Each bit of `clx_hit_i` that is high at a clock edge is ORed into the latch, even on the clearing edge.
- R7: A read of offset 0x002 returns the long-field flag in bit 15, vertical position bit 8 in bit 0, and zero elsewhere.
- R8: A read of offset 0x004 returns vertical position bits 7..0 in bits 15..8 and line cycle count bits 8..1 in bits 7..0.
- R9: A write to offset 0x020 loads the long-field flag from data bit 15.
- R10: A read of offset 0x000 returns the DMA control word ORed with `blit_stat_i`. Offset 0x00C returns 0x3000 (transmit buffer empty). Offset 0x00A returns 0xFF00.
- R11: `irq_pending_o` is high exactly when interrupt enable bit 14 is set and the AND of request and enable bits 13..0 is nonzero.
- R12: A write at any offset of 0x040 or above pulses `ext_we_o` for one cycle after the access edge, with `ext_off_o` and `ext_data_o` carrying the offset and the data. A read there pulses it with data 0xFFFF.
- R13: After reset all registers, `rd_data_o` and the outputs are zero. Read data is registered and valid in the cycle after the read strobe. Offsets 0x012 to 0x01E and 0x02C to 0x03E are mapped in neither direction, and an access there has no effect apart from the 0xFFFF read result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid_i | input | 1 | Access strobe, one per cycle |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | ADDR_W | Bus byte address |
| acc_wdata_i | input | 16 | Write data |
| rd_data_o | output | 16 | Registered read data |
| blit_stat_i | input | 16 | Blitter status bits merged into DMA readback |
| beam_v_i | input | 9 | Vertical beam position |
| beam_hcyc_i | input | 9 | Line cycle count |
| clx_hit_i | input | 16 | Collision hit bits to latch |
| dma_ctl_o | output | 16 | DMA control word |
| adk_ctl_o | output | 16 | Audio/disk control word |
| clx_ctrl_o | output | 16 | Collision control word |
| irq_pending_o | output | 1 | Enabled interrupt pending |
| ext_we_o | output | 1 | External register write pulse |
| ext_off_o | output | 9 | Offset of the external write |
| ext_data_o | output | 16 | Data of the external write |

## Verification
A wrong set/clear decision or mask shows on `dma_ctl_o` or `adk_ctl_o` in the cycle after the write, and in the readback data one cycle after a later read. Interrupt state that has gone wrong shows on `irq_pending_o` one cycle after the enable or request write that should have changed it. A cross-access that takes the wrong path shows in one of two ways: a missing or extra external strobe in the next cycle, or a register that has changed when it should not. The bench finds the second case by reading back that register. Collision hits that were lost, or a clear that never happened, show in the value of the next collision read.

// File: rtl/chip_regs_pkg.sv
package chip_regs_pkg;

    localparam int DW    = 16;
    localparam int OFF_W = 9;

    localparam logic [DW-1:0] DMA_MASK = 16'h1FFF;
    localparam logic [DW-1:0] INT_MASK = 16'h7FFF;
    localparam logic [DW-1:0] ALL_ONES = 16'hFFFF;
    localparam logic [DW-1:0] SER_IDLE = 16'h3000;
    localparam logic [DW-1:0] POT_IDLE = 16'hFF00;

    // readable offsets
    localparam logic [OFF_W-1:0] O_RD_DMA   = 9'h000;
    localparam logic [OFF_W-1:0] O_RD_VPOS  = 9'h002;
    localparam logic [OFF_W-1:0] O_RD_VHPOS = 9'h004;
    localparam logic [OFF_W-1:0] O_RD_CLX   = 9'h006;
    localparam logic [OFF_W-1:0] O_RD_ADK   = 9'h008;
    localparam logic [OFF_W-1:0] O_RD_POT   = 9'h00A;
    localparam logic [OFF_W-1:0] O_RD_SER   = 9'h00C;
    localparam logic [OFF_W-1:0] O_RD_INTEN = 9'h00E;
    localparam logic [OFF_W-1:0] O_RD_INTRQ = 9'h010;
    // writable offsets
    localparam logic [OFF_W-1:0] O_WR_POS   = 9'h020;
    localparam logic [OFF_W-1:0] O_WR_CLXC  = 9'h022;
    localparam logic [OFF_W-1:0] O_WR_DMA   = 9'h024;
    localparam logic [OFF_W-1:0] O_WR_INTEN = 9'h026;
    localparam logic [OFF_W-1:0] O_WR_INTRQ = 9'h028;
    localparam logic [OFF_W-1:0] O_WR_ADK   = 9'h02A;

    typedef enum logic [3:0] {
        RS_NONE, RS_DMA, RS_VPOS, RS_VHPOS, RS_CLX, RS_ADK,
        RS_POT, RS_SER, RS_INTEN, RS_INTRQ
    } rd_sel_e;

    typedef enum logic [2:0] {
        WS_NONE, WS_POS, WS_CLXC, WS_DMA, WS_INTEN, WS_INTRQ, WS_ADK, WS_EXT
    } wr_sel_e;

    typedef struct packed {
        logic            we;
        logic [OFF_W-1:0] off;
        logic [DW-1:0]   data;
    } ext_wr_t;

    // set/clear update: bit 15 picks the direction
    function automatic logic [DW-1:0] set_clear(input logic [DW-1:0] cur,
                                                input logic [DW-1:0] din,
                                                input logic [DW-1:0] mask);
        logic [DW-1:0] bits;
        bits = din & mask;
        return din[DW-1] ? (cur | bits) : (cur & ~bits);
    endfunction

endpackage

// File: rtl/chip_decode.sv
module chip_decode
    import chip_regs_pkg::*;
#(
    parameter logic [OFF_W-1:0] EXT_BASE = 9'h040
) (
    input  logic [OFF_W-1:0] off_i,
    output rd_sel_e          rd_sel_o,
    output wr_sel_e          wr_sel_o
);

    always_comb begin
        unique case (off_i)
            O_RD_DMA:   rd_sel_o = RS_DMA;
            O_RD_VPOS:  rd_sel_o = RS_VPOS;
            O_RD_VHPOS: rd_sel_o = RS_VHPOS;
            O_RD_CLX:   rd_sel_o = RS_CLX;
            O_RD_ADK:   rd_sel_o = RS_ADK;
            O_RD_POT:   rd_sel_o = RS_POT;
            O_RD_SER:   rd_sel_o = RS_SER;
            O_RD_INTEN: rd_sel_o = RS_INTEN;
            O_RD_INTRQ: rd_sel_o = RS_INTRQ;
            default:    rd_sel_o = RS_NONE;
        endcase
    end

    always_comb begin
        if (off_i >= EXT_BASE) begin
            wr_sel_o = WS_EXT;
        end else begin
            unique case (off_i)
                O_WR_POS:   wr_sel_o = WS_POS;
                O_WR_CLXC:  wr_sel_o = WS_CLXC;
                O_WR_DMA:   wr_sel_o = WS_DMA;
                O_WR_INTEN: wr_sel_o = WS_INTEN;
                O_WR_INTRQ: wr_sel_o = WS_INTRQ;
                O_WR_ADK:   wr_sel_o = WS_ADK;
                default:    wr_sel_o = WS_NONE;
            endcase
        end
    end

    // R13: no offset is both readable and writable
    always_comb begin
        a_dir_exclusive_r13: assert (!(rd_sel_o != RS_NONE && wr_sel_o != WS_NONE));
    end

endmodule

// File: rtl/chip_setclr_reg.sv
module chip_setclr_reg
    import chip_regs_pkg::*;
#(
    parameter logic [DW-1:0] MASK = 16'h7FFF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic [DW-1:0] din_i,
    output logic [DW-1:0] q_o
);

    always_ff @(posedge clk) begin
        if (rst)       q_o <= '0;
        else if (we_i) q_o <= set_clear(q_o, din_i, MASK);
    end

    p_set_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (we_i && din_i[DW-1]) |=> ((q_o & $past(din_i) & MASK) == ($past(din_i) & MASK)));

    p_clear_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (we_i && !din_i[DW-1]) |=> ((q_o & $past(din_i) & MASK) == '0));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable(q_o));

endmodule

// File: rtl/chip_regbus.sv
module chip_regbus
    import chip_regs_pkg::*;
#(
    parameter int              ADDR_W   = 24,
    parameter logic [8:0]      EXT_BASE = 9'h040
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid_i,
    input  logic              acc_wr_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [15:0]       acc_wdata_i,
    output logic [15:0]       rd_data_o,
    input  logic [15:0]       blit_stat_i,
    input  logic [8:0]        beam_v_i,
    input  logic [8:0]        beam_hcyc_i,
    input  logic [15:0]       clx_hit_i,
    output logic [15:0]       dma_ctl_o,
    output logic [15:0]       adk_ctl_o,
    output logic [15:0]       clx_ctrl_o,
    output logic              irq_pending_o,
    output logic              ext_we_o,
    output logic [8:0]        ext_off_o,
    output logic [15:0]       ext_data_o
);

    logic [OFF_W-1:0] off;
    assign off = {acc_addr_i[8:1], 1'b0};

    logic unused_bits;
    assign unused_bits = ^{acc_addr_i[ADDR_W-1:9], acc_addr_i[0], beam_hcyc_i[0]};

    rd_sel_e rd_sel;
    wr_sel_e wr_sel;

    chip_decode #(.EXT_BASE(EXT_BASE)) decode_i (
        .off_i   (off),
        .rd_sel_o(rd_sel),
        .wr_sel_o(wr_sel)
    );

    // effective operations after cross-access redirection
    logic          eff_rd, eff_wr, load_rd;
    logic [DW-1:0] eff_wdata;
    always_comb begin
        load_rd   = acc_valid_i && !acc_wr_i;
        eff_rd    = acc_valid_i && (!acc_wr_i || wr_sel == WS_NONE);
        eff_wr    = acc_valid_i && ( acc_wr_i || rd_sel == RS_NONE);
        eff_wdata = acc_wr_i ? acc_wdata_i : ALL_ONES;
    end

    logic we_dma, we_inten, we_intrq, we_adk;
    assign we_dma   = eff_wr && wr_sel == WS_DMA;
    assign we_inten = eff_wr && wr_sel == WS_INTEN;
    assign we_intrq = eff_wr && wr_sel == WS_INTRQ;
    assign we_adk   = eff_wr && wr_sel == WS_ADK;

    logic [DW-1:0] int_en, int_rq;

    chip_setclr_reg #(.MASK(DMA_MASK)) dma_reg_i (
        .clk(clk), .rst(rst), .we_i(we_dma),   .din_i(eff_wdata), .q_o(dma_ctl_o));
    chip_setclr_reg #(.MASK(INT_MASK)) inten_reg_i (
        .clk(clk), .rst(rst), .we_i(we_inten), .din_i(eff_wdata), .q_o(int_en));
    chip_setclr_reg #(.MASK(INT_MASK)) intrq_reg_i (
        .clk(clk), .rst(rst), .we_i(we_intrq), .din_i(eff_wdata), .q_o(int_rq));
    chip_setclr_reg #(.MASK(INT_MASK)) adk_reg_i (
        .clk(clk), .rst(rst), .we_i(we_adk),   .din_i(eff_wdata), .q_o(adk_ctl_o));

    // plain registers, collision latch, external strobe
    logic          long_field;
    logic [DW-1:0] clx_latch;
    ext_wr_t       ext_q;
    logic          clx_clear;
    assign clx_clear = eff_rd && rd_sel == RS_CLX;

    always_ff @(posedge clk) begin
        if (rst) begin
            long_field <= 1'b0;
            clx_ctrl_o <= '0;
            clx_latch  <= '0;
            ext_q      <= '0;
        end else begin
            if (eff_wr && wr_sel == WS_POS)  long_field <= eff_wdata[15];
            if (eff_wr && wr_sel == WS_CLXC) clx_ctrl_o <= eff_wdata;
            clx_latch <= (clx_clear ? '0 : clx_latch) | clx_hit_i;
            ext_q.we   <= eff_wr && wr_sel == WS_EXT;
            ext_q.off  <= off;
            ext_q.data <= eff_wdata;
        end
    end

    assign ext_we_o   = ext_q.we;
    assign ext_off_o  = ext_q.off;
    assign ext_data_o = ext_q.data;

    // read mux and registered read data
    logic [DW-1:0] rd_mux;
    always_comb begin
        unique case (rd_sel)
            RS_DMA:   rd_mux = dma_ctl_o | blit_stat_i;
            RS_VPOS:  rd_mux = {long_field, 14'd0, beam_v_i[8]};
            RS_VHPOS: rd_mux = {beam_v_i[7:0], beam_hcyc_i[8:1]};
            RS_CLX:   rd_mux = clx_latch;
            RS_ADK:   rd_mux = adk_ctl_o;
            RS_POT:   rd_mux = POT_IDLE;
            RS_SER:   rd_mux = SER_IDLE;
            RS_INTEN: rd_mux = int_en;
            RS_INTRQ: rd_mux = int_rq;
            default:  rd_mux = ALL_ONES;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)          rd_data_o <= '0;
        else if (load_rd) rd_data_o <= rd_mux;
    end

    assign irq_pending_o = int_en[14] && |(int_en[13:0] & int_rq[13:0]);

    p_unmapped_read_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_i && !acc_wr_i && rd_sel == RS_NONE) |=> (rd_data_o == ALL_ONES));

    p_write_keeps_rdata_r5: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_i && acc_wr_i) |=> $stable(rd_data_o));

    p_ext_only_on_access_r12: assert property (@(posedge clk) disable iff (rst)
        !acc_valid_i |=> !ext_we_o);

    p_clx_hits_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (clx_hit_i != '0) |=> ((clx_latch & $past(clx_hit_i)) == $past(clx_hit_i)));

endmodule

// File: tb/chip_regbus_tb_top.sv
module chip_regbus_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid, acc_wr;
    logic [23:0] acc_addr;
    logic [15:0] acc_wdata, rd_data, blit_stat, clx_hit;
    logic [8:0]  beam_v, beam_hcyc, ext_off;
    logic [15:0] dma_ctl, adk_ctl, clx_ctrl, ext_data;
    logic        irq_pending, ext_we;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chip_regbus #(.ADDR_W(24)) dut_i (
        .clk(clk), .rst(rst),
        .acc_valid_i(acc_valid), .acc_wr_i(acc_wr), .acc_addr_i(acc_addr),
        .acc_wdata_i(acc_wdata), .rd_data_o(rd_data), .blit_stat_i(blit_stat),
        .beam_v_i(beam_v), .beam_hcyc_i(beam_hcyc), .clx_hit_i(clx_hit),
        .dma_ctl_o(dma_ctl), .adk_ctl_o(adk_ctl), .clx_ctrl_o(clx_ctrl),
        .irq_pending_o(irq_pending), .ext_we_o(ext_we), .ext_off_o(ext_off),
        .ext_data_o(ext_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, sample at the following negedge
    task automatic access(input logic wr, input logic [23:0] addr, input logic [15:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_wr = wr; acc_addr = addr; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic t_reset;
        check("R13 rdata", 32'(rd_data), 0);
        check("R13 dma", 32'(dma_ctl), 0);
        check("R13 irq", 32'(irq_pending), 0);
        check("R13 ext", 32'(ext_we), 0);
    endtask

    task automatic t_setclr;
        access(1, 24'h000024, 16'hFFFF);
        check("R2 set masked", 32'(dma_ctl), 32'h1FFF);
        access(1, 24'h000024, 16'h0005);
        check("R2 clear", 32'(dma_ctl), 32'h1FFA);
        access(1, 24'h00002A, 16'hFFFF);
        check("R3 adk mask", 32'(adk_ctl), 32'h7FFF);
        access(0, 24'h000008, 16'h0);
        check("R3 adk readback", 32'(rd_data), 32'h7FFF);
    endtask

    task automatic t_addr;
        access(1, 24'hABC025, 16'h0FFA);
        check("R1 high bits and bit0 ignored", 32'(dma_ctl), 32'h1000);
        access(1, 24'h000224, 16'h8001);
        check("R1 bit9 ignored", 32'(dma_ctl), 32'h1001);
    endtask

    task automatic t_fixed_reads;
        blit_stat = 16'h4000;
        access(0, 24'h000000, 16'h0);
        check("R10 dma readback", 32'(rd_data), 32'h5001);
        blit_stat = 16'h0000;
        access(0, 24'h00000C, 16'h0);
        check("R10 serial", 32'(rd_data), 32'h3000);
        access(0, 24'h00000A, 16'h0);
        check("R10 pot", 32'(rd_data), 32'hFF00);
    endtask

    task automatic t_beam;
        beam_v = 9'h1A5; beam_hcyc = 9'h0F3;
        access(1, 24'h000020, 16'h8000);
        access(0, 24'h000002, 16'h0);
        check("R9/R7 vpos long", 32'(rd_data), 32'h8001);
        access(0, 24'h000004, 16'h0);
        check("R8 vhpos", 32'(rd_data), 32'hA579);
        access(1, 24'h000020, 16'h7FFF);
        access(0, 24'h000002, 16'h0);
        check("R9 long cleared", 32'(rd_data), 32'h0001);
    endtask

    task automatic t_collision;
        @(negedge clk); clx_hit = 16'h0012;
        @(negedge clk); clx_hit = 16'h0000;
        access(0, 24'h000006, 16'h0);
        check("R6 latched", 32'(rd_data), 32'h0012);
        access(0, 24'h000006, 16'h0);
        check("R6 cleared", 32'(rd_data), 32'h0000);
        access(1, 24'h000022, 16'h0ABC);
        check("R6 clx ctrl", 32'(clx_ctrl), 32'h0ABC);
    endtask

    task automatic t_write_to_readonly;
        @(negedge clk); clx_hit = 16'h0300;
        @(negedge clk); clx_hit = 16'h0000;
        access(0, 24'h00000A, 16'h0);
        access(1, 24'h000006, 16'h1234);
        check("R5 rdata kept", 32'(rd_data), 32'hFF00);
        access(0, 24'h000006, 16'h0);
        check("R5 read side effect cleared latch", 32'(rd_data), 32'h0000);
    endtask

    task automatic t_read_unmapped;
        access(0, 24'h000014, 16'h0);
        check("R13 double unmapped read", 32'(rd_data), 32'hFFFF);
        access(0, 24'h00000E, 16'h0);
        check("R13 inten untouched", 32'(rd_data), 32'h0000);
        access(0, 24'h000026, 16'h0);
        check("R4 unmapped read data", 32'(rd_data), 32'hFFFF);
        access(0, 24'h00000E, 16'h0);
        check("R4 read wrote inten", 32'(rd_data), 32'h7FFF);
    endtask

    task automatic t_irq;
        check("R11 no request", 32'(irq_pending), 0);
        access(1, 24'h000028, 16'h8004);
        check("R11 pending", 32'(irq_pending), 1);
        access(1, 24'h000026, 16'h4000);
        check("R11 master off", 32'(irq_pending), 0);
        access(1, 24'h000026, 16'hC000);
        check("R11 master on", 32'(irq_pending), 1);
        access(1, 24'h000028, 16'h0004);
        check("R11 request cleared", 32'(irq_pending), 0);
        access(0, 24'h000010, 16'h0);
        check("R3 intreq readback", 32'(rd_data), 32'h0000);
    endtask

    task automatic t_ext;
        access(1, 24'h0000A4, 16'hBEEF);
        check("R12 we", 32'(ext_we), 1);
        check("R12 off", 32'(ext_off), 32'h0A4);
        check("R12 data", 32'(ext_data), 32'hBEEF);
        @(negedge clk);
        check("R12 one pulse", 32'(ext_we), 0);
        access(0, 24'h0001FE, 16'h0);
        check("R12 read pulses", 32'(ext_we), 1);
        check("R12 read data ones", 32'(ext_data), 32'hFFFF);
        check("R4 ext read data", 32'(rd_data), 32'hFFFF);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; acc_valid = 1'b0; acc_wr = 1'b0; acc_addr = '0; acc_wdata = '0;
        blit_stat = '0; beam_v = '0; beam_hcyc = '0; clx_hit = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_setclr();
        t_addr();
        t_fixed_reads();
        t_beam();
        t_collision();
        t_write_to_readonly();
        t_read_unmapped();
        t_irq();
        t_ext();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule